// File: doc/BRIEF.md
# Management Data Clock/IO Serial Master

This block is the master side of a two-wire station-management link to an Ethernet PHY. It generates the management clock, drives the shared data line through a separate output enable, and reads the line back during turnaround and data phases. A host hands it one request at a time over a valid/ready port. A request carries an operation code, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. When the frame is finished the block raises a one-cycle done strobe. For reads, the 16-bit result is presented on the same cycle.

Three kinds of frame are supported. A sync frame is a stand-alone preamble of ones. A read frame drives a 16-bit command, then releases the line and samples 19 bit periods. It keeps bits 16:1 of the sampled word, so the last sampled bit is discarded. A write frame drives a complete 32-bit word, then releases the line for two more clock periods. The management clock rate comes from the system clock frequency and a ceiling frequency, both given as parameters.

Top module: `mdio_master`

## Requirements
- R1: Operation code 2 or 3 (sync) drives 32 clock periods with output enable high and data high in every period.
- R2: Operation code 0 (read) first drives 16 bits MSB first: 1,1, then 0,1, then 1,0, then PHY address bits 4..0, then register address bits 4..0.
- R3: A read follows its command with 19 periods in which the output enable is low. The input is sampled once per period, MSB first. `rd_data` equals bits 16:1 of the 19-bit sampled word and changes only on a read's done cycle.
- R4: Operation code 1 (write) drives 32 bits MSB first: 0,1, then 0,1, then PHY address, then register address, then 1,0, then write data bits 15..0.
- R5: After the 32 driven bits of a write, two more clock periods follow with the output enable low, and only then is done raised.
- R6: The data and output enable change only while the clock is low and stay stable while it is high. The input is sampled on the last system cycle of each low phase.
- R7: `req_ready` is high only while idle. A request is taken only when valid and ready are both high. Requests presented while busy are ignored and start no frame.
- R8: During reset and while idle, the clock and output enable are low and ready is high. After reset, done is low and `rd_data` is zero.
- R9: Done is a one-cycle pulse. It rises exactly (periods × 2 × HALF) system cycles after the accepting edge, where periods is 32, 35 or 34 for sync, read and write.
- R10: Each clock low phase and each high phase lasts HALF = ceil(SYS_CLK_HZ / (2 × MDC_MAX_HZ)) system cycles. The management clock therefore never exceeds MDC_MAX_HZ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, able to take a request |
| req_op | input | 2 | 0 read, 1 write, 2 or 3 sync |
| req_phy | input | 5 | PHY address |
| req_addr | input | 5 | Register address inside the PHY |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-cycle frame completion strobe |
| rd_data | output | 16 | Result of the last read |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | Data line output enable |
| mdio_out | output | 1 | Data value driven when enabled |
| mdio_in | input | 1 | Sampled data line |

## Verification
The properties assume that `rst_n` is held long enough to clear the clock and enable registers. They also assume `mdio_in` is settled by the last cycle of each low phase, and that the host deasserts `req_valid` before done if it wants no second frame. The stimulus changes the PHY response bit only just after a clock rise, so it is stable at every sampling point. It raises stray requests only in the middle of a frame, and it drops them well before completion. The sweeps walk every PHY address for reads and writes, with varied register addresses, data and response words that include all-zero and all-one cases.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int FRAME_W   = 32;
    localparam int CAP_W     = 19;
    localparam int CNT_W     = 6;
    localparam int RD_DRIVE  = 16;
    localparam int RD_SAMPLE = 19;
    localparam int WR_DRIVE  = 32;
    localparam int WR_TAIL   = 2;
    localparam int SYNC_LEN  = 32;

    localparam logic [1:0] PAT_LEAD  = 2'b11;
    localparam logic [1:0] PAT_START = 2'b01;
    localparam logic [1:0] PAT_RDOP  = 2'b10;
    localparam logic [1:0] PAT_WROP  = 2'b01;
    localparam logic [1:0] PAT_TURN  = 2'b10;

    localparam logic [1:0] OPC_READ  = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } mm_state_e;

    typedef struct packed {
        mm_state_e          st;
        logic [FRAME_W-1:0] shift;
        logic [CNT_W-1:0]   drive_left;
        logic [CNT_W-1:0]   total_left;
        logic [CAP_W-1:0]   cap;
        logic               is_read;
        logic               mdc;
        logic               oe;
        logic               dout;
        logic               done;
        logic [15:0]        rdata;
    } mm_regs_t;

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
    parameter int HALF = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_comb begin
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_frame_build.sv
module mdio_frame_build
    import mdio_pkg::*;
(
    input  logic [1:0]         op,
    input  logic [4:0]         phy,
    input  logic [4:0]         regad,
    input  logic [15:0]        wdata,
    output logic [FRAME_W-1:0] word,
    output logic [CNT_W-1:0]   n_drive,
    output logic [CNT_W-1:0]   n_total,
    output logic               is_read
);
    always_comb begin
        is_read = 1'b0;
        case (op)
            OPC_READ: begin
                word    = {PAT_LEAD, PAT_START, PAT_RDOP, phy, regad, 16'h0000};
                n_drive = CNT_W'(RD_DRIVE);
                n_total = CNT_W'(RD_DRIVE + RD_SAMPLE);
                is_read = 1'b1;
            end
            OPC_WRITE: begin
                word    = {PAT_START, PAT_WROP, phy, regad, PAT_TURN, wdata};
                n_drive = CNT_W'(WR_DRIVE);
                n_total = CNT_W'(WR_DRIVE + WR_TAIL);
            end
            default: begin
                word    = '1;
                n_drive = CNT_W'(SYNC_LEN);
                n_total = CNT_W'(SYNC_LEN);
            end
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
    import mdio_pkg::*;
#(
    parameter int SYS_CLK_HZ = 100_000_000,
    parameter int MDC_MAX_HZ = 2_500_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [1:0]  req_op,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_oe,
    output logic        mdio_out,
    input  logic        mdio_in
);
    localparam int HALF_CYC = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

    mm_regs_t q, d;

    logic               tick;
    logic [FRAME_W-1:0] fb_word;
    logic [CNT_W-1:0]   fb_drive, fb_total;
    logic               fb_is_read;
    logic [CNT_W-1:0]   nxt_drive;

    mdio_half_timer #(.HALF(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (q.st != ST_IDLE),
        .tick  (tick)
    );

    mdio_frame_build u_build (
        .op      (req_op),
        .phy     (req_phy),
        .regad   (req_addr),
        .wdata   (req_wdata),
        .word    (fb_word),
        .n_drive (fb_drive),
        .n_total (fb_total),
        .is_read (fb_is_read)
    );

    assign nxt_drive = (q.drive_left != '0) ? q.drive_left - 1'b1 : '0;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                d.mdc = 1'b0;
                d.oe  = 1'b0;
                if (req_valid) begin
                    d.st         = ST_LOW;
                    d.shift      = fb_word;
                    d.drive_left = fb_drive;
                    d.total_left = fb_total;
                    d.cap        = '0;
                    d.is_read    = fb_is_read;
                    d.oe         = 1'b1;
                    d.dout       = fb_word[FRAME_W-1];
                end
            end
            ST_LOW: begin
                if (tick) begin
                    d.mdc = 1'b1;
                    d.st  = ST_HIGH;
                    if (q.is_read && q.drive_left == '0)
                        d.cap = {q.cap[CAP_W-2:0], mdio_in};
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    d.mdc        = 1'b0;
                    d.shift      = q.shift << 1;
                    d.drive_left = nxt_drive;
                    d.total_left = q.total_left - 1'b1;
                    if (q.total_left == CNT_W'(1)) begin
                        d.st   = ST_IDLE;
                        d.oe   = 1'b0;
                        d.dout = 1'b0;
                        d.done = 1'b1;
                        if (q.is_read) d.rdata = q.cap[16:1];
                    end else begin
                        d.st = ST_LOW;
                        if (nxt_drive != '0) begin
                            d.oe   = 1'b1;
                            d.dout = q.shift[FRAME_W-2];
                        end else begin
                            d.oe   = 1'b0;
                            d.dout = 1'b0;
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign done      = q.done;
    assign rd_data   = q.rdata;
    assign mdc       = q.mdc;
    assign mdio_oe   = q.oe;
    assign mdio_out  = q.dout;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
    parameter int SYS_CLK_HZ = 100_000_000,
    parameter int MDC_MAX_HZ = 2_500_000
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic        done,
    input logic [15:0] rd_data,
    input logic        mdc,
    input logic        mdio_oe,
    input logic        mdio_out
);
    localparam int HALF = (SYS_CLK_HZ + 2 * MDC_MAX_HZ - 1) / (2 * MDC_MAX_HZ);

    logic [15:0] hi_cnt, lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else begin
            hi_cnt <= mdc ? hi_cnt + 16'd1 : 16'd0;
            lo_cnt <= (!mdc && !req_ready) ? lo_cnt + 16'd1 : 16'd0;
        end
    end

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mdio_oe && !mdc));

    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> req_ready);

    p_hold_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> ($stable(mdio_oe) && $stable(mdio_out)));

    p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rd_data));

    p_high_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc) |-> (hi_cnt == 16'(HALF)));

    p_low_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> (lo_cnt == 16'(HALF)));
endmodule

bind mdio_master mdio_master_chk #(
    .SYS_CLK_HZ (SYS_CLK_HZ),
    .MDC_MAX_HZ (MDC_MAX_HZ)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .rd_data   (rd_data),
    .mdc       (mdc),
    .mdio_oe   (mdio_oe),
    .mdio_out  (mdio_out)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
    localparam int SYS  = 12_000_000;
    localparam int MAXF = 2_500_000;
    localparam int H    = (SYS + 2 * MAXF - 1) / (2 * MAXF);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [4:0]  req_phy = 5'd0;
    logic [4:0]  req_addr = 5'd0;
    logic [15:0] req_wdata = 16'd0;
    logic        done;
    logic [15:0] rd_data;
    logic        mdc, mdio_oe, mdio_out, mdio_in;

    mdio_master #(.SYS_CLK_HZ(SYS), .MDC_MAX_HZ(MAXF)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_phy(req_phy), .req_addr(req_addr),
        .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .mdc(mdc),
        .mdio_oe(mdio_oe), .mdio_out(mdio_out), .mdio_in(mdio_in)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // PHY-side monitor: records each clock rise and the period between rises
    logic        clr = 1'b0;
    logic        prev_mdc = 1'b0;
    int          rise_cnt = 0;
    int          last_rise = -1;
    int          bad_period = 0;
    logic        rec_oe [64];
    logic        rec_out [64];
    logic [18:0] rd_pat = 19'd0;

    always @(negedge clk) begin
        if (clr) begin
            rise_cnt   = 0;
            last_rise  = -1;
            bad_period = 0;
        end else if (mdc && !prev_mdc) begin
            if (rise_cnt < 64) begin
                rec_oe[rise_cnt]  = mdio_oe;
                rec_out[rise_cnt] = mdio_out;
            end
            if (last_rise >= 0 && (cyc - last_rise) != 2 * H) bad_period++;
            last_rise = cyc;
            rise_cnt++;
        end
        prev_mdc = mdc;
    end

    assign mdio_in = (rise_cnt >= 16 && rise_cnt < 35) ? rd_pat[5'(34 - rise_cnt)] : 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] ra, input logic [15:0] wd,
                          input logic [18:0] pat, input bit poke);
        logic [31:0] w;
        int nd, nr, c0;
        bit busy_ok;
        string dtag, rtag;
        if (op == 2'd0) begin
            w = {2'b11, 2'b01, 2'b10, phy, ra, 16'h0000}; nd = 16; nr = 19;
            dtag = "R2"; rtag = "R3";
        end else if (op == 2'd1) begin
            w = {2'b01, 2'b01, phy, ra, 2'b10, wd}; nd = 32; nr = 2;
            dtag = "R4"; rtag = "R5";
        end else begin
            w = 32'hFFFF_FFFF; nd = 32; nr = 0;
            dtag = "R1"; rtag = "R1";
        end
        rd_pat = pat;
        @(negedge clk) clr = 1'b1;
        @(posedge clk);
        @(posedge clk) clr = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_phy = phy; req_addr = ra; req_wdata = wd;
        @(posedge clk);
        #1;
        req_valid = poke; req_op = 2'd2; req_phy = ~phy; req_wdata = ~wd;
        @(negedge clk);
        c0 = cyc;
        busy_ok = 1'b1;
        for (int k = 0; k < 5000 && !done; k++) begin
            if (req_ready) busy_ok = 1'b0;
            if (k == 4) req_valid = 1'b0;
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(done, "R9", "done seen", 32'(done), 32'd1);
        chk((cyc - c0) == (nd + nr) * 2 * H, "R9", "frame duration",
            32'(cyc - c0), 32'((nd + nr) * 2 * H));
        chk(busy_ok, "R7", "ready low while busy", 32'(busy_ok), 32'd1);
        chk(rise_cnt == nd + nr, dtag, "clock periods", 32'(rise_cnt), 32'(nd + nr));
        chk(bad_period == 0, "R10", "rise spacing errors", 32'(bad_period), 32'd0);
        for (int i = 0; i < nd; i++)
            chk(rec_oe[i] && (rec_out[i] == w[31-i]), dtag, "driven bit",
                {30'd0, rec_oe[i], rec_out[i]}, {30'd0, 1'b1, w[31-i]});
        for (int i = nd; i < nd + nr; i++)
            chk(!rec_oe[i], rtag, "released period", 32'(rec_oe[i]), 32'd0);
        if (op == 2'd0)
            chk(rd_data == pat[16:1], "R3", "read data (R6 sampling point)",
                32'(rd_data), 32'(pat[16:1]));
        @(negedge clk);
        chk(!done, "R9", "done width", 32'(done), 32'd0);
        chk(!mdio_oe && !mdc && req_ready, "R8", "idle outputs",
            {29'd0, mdio_oe, mdc, req_ready}, 32'd1);
        repeat (6 * H) @(negedge clk);
        chk(rise_cnt == nd + nr, "R7", "no frame from busy request",
            32'(rise_cnt), 32'(nd + nr));
    endtask

    localparam int WD_LIMIT = 150_000;
    always @(posedge clk) begin
        if (cyc == WD_LIMIT) begin
            errors++;
            $display("FAIL R9 watchdog actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!mdio_oe && !mdc && req_ready && !done && rd_data == 16'd0, "R8",
            "reset state", {12'd0, mdio_oe, mdc, req_ready, done, rd_data},
            32'h0002_0000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_op(2'd2, 5'd0, 5'd0, 16'd0, 19'd0, 1'b0);
        run_op(2'd3, 5'd9, 5'd4, 16'h1234, 19'd0, 1'b1);

        for (int p = 0; p < 32; p++)
            run_op(2'd0, 5'(p), 5'(p * 7 + 3), 16'd0,
                   19'(p * 32'h2F35 ^ 32'h5A5A5), (p % 4) == 0);
        run_op(2'd0, 5'd31, 5'd31, 16'd0, 19'h7FFFF, 1'b0);
        run_op(2'd0, 5'd0, 5'd0, 16'd0, 19'h00000, 1'b0);

        for (int p = 0; p < 32; p++)
            run_op(2'd1, 5'(p), 5'(31 - p), 16'(p * 16'h1357 ^ 16'hA5C3),
                   19'h7FFFF, (p % 5) == 1);
        run_op(2'd1, 5'd21, 5'd10, 16'h0000, 19'd0, 1'b0);
        run_op(2'd1, 5'd10, 5'd21, 16'hFFFF, 19'd0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule